// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a small bank of board-control registers on a plain synchronous register bus. The bus has an address, a write enable with write data, and a read strobe. Software uses it to drive status LEDs, keep software-defined flag bits, read the board identity, and ask for a system reset. The flag bits come in two kinds. The volatile set is cleared by reset. The persistent set keeps its value through reset. Each set has one address for write-one-to-set, which is also its read address, and another address for write-one-to-clear.

The reset-control register is guarded by a lock. A write to it is only accepted while the lock register holds the 16-bit key 0xA05F. Any other value written to the lock is stored with its top bit cleared, so the key can never be stored by accident. When an accepted write to the reset-control register carries a 1 in the board's reset bit, the block raises a one-cycle reset request. The board identity is a parameter. Its board-type field decides which bit is the reset bit, or whether the register exists at all.

Top module: `sysreg_bank`

## Requirements
- R1: Offset 0x00 reads the identity parameter, whose board type is bits 27:16; writes to it change nothing.
- R2: Writing 0xA05F to the lock register at 0x20 stores that key. Any other value is stored as its low 16 bits with bit 15 cleared. Reads return the 16-bit lock value zero-extended.
- R3: A write to reset control at 0x40 is accepted only while the lock holds the key; otherwise it is dropped.
- R4: An accepted reset-control write with the reset bit set raises `rst_req` for exactly the following cycle. The reset bit is bit 8 for board type 0x100 and bit 2 for board types 0x178 and 0x182. An accepted write stores the written value, and 0x40 reads it back.
- R5: For all other board types, 0x40 reads zero, ignores writes, and never raises `rst_req`.
- R6: Volatile flags: a write to 0x30 ORs the data into the flags, a write to 0x34 clears the flag bits where the data has ones, and 0x30 reads the flags. A read of 0x34 returns zero.
- R7: Persistent flags work the same way, with 0x38 for set and read and 0x3C for clear. Reset does not change them.
- R8: The LED register at 0x08 stores all 32 written bits and reads them back.
- R9: Offset 0x44 always reads 1, and offset 0x88 always reads 0xFF000000.
- R10: Reset clears the LED, lock, volatile flag and reset-control registers.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_re`. An access to an undecoded offset reads zero, changes no register, and raises `bus_err` for that same following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DW | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DW | Registered read data |
| bus_err | output | 1 | One-cycle strobe for an undecoded access |
| rst_req | output | 1 | One-cycle software reset request |

## Verification
The hardest state to reach is an accepted reset-control write. It needs two earlier steps: the exact key must be written to the lock, and it must not be overwritten afterwards. The stimulus first tries the write while the register is locked. It then writes a near-miss value (0xFFFF) to the lock, checks that this value reads back without the key's top bit, and only then stores the key. Three instances with different board types share one bus. A single accepted write can therefore show the bit-2 pulse, the bit-8 pulse and the missing register side by side.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

    typedef enum logic [1:0] {
        RV_NONE = 2'd0,
        RV_BIT8 = 2'd1,
        RV_BIT2 = 2'd2
    } rst_variant_e;

    function automatic rst_variant_e variant_of(input logic [11:0] board);
        case (board)
            12'h100:          return RV_BIT8;
            12'h178, 12'h182: return RV_BIT2;
            default:          return RV_NONE;
        endcase
    endfunction

    localparam logic [11:0] OFF_IDENT  = 12'h000;
    localparam logic [11:0] OFF_LED    = 12'h008;
    localparam logic [11:0] OFF_LOCK   = 12'h020;
    localparam logic [11:0] OFF_FL_SET = 12'h030;
    localparam logic [11:0] OFF_FL_CLR = 12'h034;
    localparam logic [11:0] OFF_NV_SET = 12'h038;
    localparam logic [11:0] OFF_NV_CLR = 12'h03C;
    localparam logic [11:0] OFF_RSTCTL = 12'h040;
    localparam logic [11:0] OFF_PCIRO  = 12'h044;
    localparam logic [11:0] OFF_PID1   = 12'h088;

endpackage

// File: rtl/sysreg_lock.sv
module sysreg_lock
    import sysreg_pkg::*;
#(
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [KW-1:0] wdata,
    output logic [KW-1:0] lock_q,
    output logic          unlocked
);
    logic [KW-1:0] lock_d;

    always_comb begin
        lock_d = lock_q;
        if (wr_en) begin
            if (wdata == UNLOCK_KEY) lock_d = wdata;
            else                     lock_d = {1'b0, wdata[KW-2:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign unlocked = (lock_q == UNLOCK_KEY);
endmodule

// File: rtl/sysreg_flags.sv
module sysreg_flags #(
    parameter int W          = 32,
    parameter bit RESETTABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flags_q
);
    logic [W-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (set_en) flags_d = flags_q | wdata;
        if (clr_en) flags_d = flags_q & ~wdata;
    end

    generate
        if (RESETTABLE) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) flags_q <= '0;
                else        flags_q <= flags_d;
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                flags_q <= flags_d;
            end
        end
    endgenerate
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int          AW    = 12,
    parameter int          DW    = 32,
    parameter logic [31:0] IDENT = 32'h0178_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    output logic          rst_req
);
    localparam int           KW      = 16;
    localparam rst_variant_e VARIANT = variant_of(IDENT[27:16]);
    localparam int           RST_BIT = (VARIANT == RV_BIT8) ? 8 : 2;
    localparam bit           HAS_RST = (VARIANT != RV_NONE);

    typedef struct packed {
        logic [DW-1:0] led;
        logic [DW-1:0] rstctl;
        logic [DW-1:0] rdata;
        logic          err;
        logic          req;
    } state_t;

    state_t state_d, state_q;

    logic [KW-1:0] lock_q;
    logic          unlocked;
    logic [DW-1:0] fl_q, nv_q;
    logic          hit_led, hit_lock, hit_fs, hit_fc, hit_ns, hit_nc, hit_rst;
    logic          decoded;
    logic [DW-1:0] rd_mux;

    always_comb begin
        hit_led  = (bus_addr == AW'(OFF_LED));
        hit_lock = (bus_addr == AW'(OFF_LOCK));
        hit_fs   = (bus_addr == AW'(OFF_FL_SET));
        hit_fc   = (bus_addr == AW'(OFF_FL_CLR));
        hit_ns   = (bus_addr == AW'(OFF_NV_SET));
        hit_nc   = (bus_addr == AW'(OFF_NV_CLR));
        hit_rst  = (bus_addr == AW'(OFF_RSTCTL));
        decoded  = hit_led | hit_lock | hit_fs | hit_fc | hit_ns | hit_nc | hit_rst
                 | (bus_addr == AW'(OFF_IDENT)) | (bus_addr == AW'(OFF_PCIRO))
                 | (bus_addr == AW'(OFF_PID1));
    end

    sysreg_lock #(.KW(KW)) lock_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we & hit_lock), .wdata(bus_wdata[KW-1:0]),
        .lock_q(lock_q), .unlocked(unlocked)
    );

    sysreg_flags #(.W(DW), .RESETTABLE(1'b1)) vflags_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(bus_we & hit_fs), .clr_en(bus_we & hit_fc),
        .wdata(bus_wdata), .flags_q(fl_q)
    );

    sysreg_flags #(.W(DW), .RESETTABLE(1'b0)) nvflags_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(bus_we & hit_ns), .clr_en(bus_we & hit_nc),
        .wdata(bus_wdata), .flags_q(nv_q)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            AW'(OFF_IDENT):  rd_mux = DW'(IDENT);
            AW'(OFF_LED):    rd_mux = state_q.led;
            AW'(OFF_LOCK):   rd_mux = DW'(lock_q);
            AW'(OFF_FL_SET): rd_mux = fl_q;
            AW'(OFF_NV_SET): rd_mux = nv_q;
            AW'(OFF_RSTCTL): rd_mux = HAS_RST ? state_q.rstctl : '0;
            AW'(OFF_PCIRO):  rd_mux = DW'(1);
            AW'(OFF_PID1):   rd_mux = DW'(32'hFF00_0000);
            default:         rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d     = state_q;
        state_d.err = 1'b0;
        state_d.req = 1'b0;
        if (bus_we && hit_led) state_d.led = bus_wdata;
        if (HAS_RST && bus_we && hit_rst && unlocked) begin
            state_d.rstctl = bus_wdata;
            state_d.req    = bus_wdata[RST_BIT];
        end
        if (bus_re) state_d.rdata = rd_mux;
        if ((bus_we || bus_re) && !decoded) state_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata = state_q.rdata;
    assign bus_err   = state_q.err;
    assign rst_req   = state_q.req;
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
    import sysreg_pkg::*;
#(
    parameter int          AW    = 12,
    parameter int          DW    = 32,
    parameter logic [31:0] IDENT = 32'h0178_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_we,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_re,
    input logic          bus_err,
    input logic          rst_req,
    input logic [15:0]   lock_val,
    input logic          unlocked,
    input logic [DW-1:0] rstctl
);
    localparam rst_variant_e VARIANT = variant_of(IDENT[27:16]);
    localparam int           RST_BIT = (VARIANT == RV_BIT8) ? 8 : 2;

    // R2: the top bit can only be set when the full key is stored
    a_r2_msb_only_key: assert property (@(posedge clk) disable iff (!rst_n)
        lock_val[15] |-> (lock_val == UNLOCK_KEY));

    // R3: a write while locked leaves reset control untouched
    a_r3_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(OFF_RSTCTL) && !unlocked) |=> $stable(rstctl));

    // R4: every request pulse traces back to an accepted write with the reset bit
    a_r4_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(bus_we && bus_addr == AW'(OFF_RSTCTL) && unlocked
                          && bus_wdata[RST_BIT]));

    // R11: an error strobe follows a bus access
    a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_we || bus_re));

    generate
        if (VARIANT == RV_NONE) begin : g_none
            // R5: no reset-control storage and no request on these boards
            a_r5_no_rstctl: assert property (@(posedge clk) disable iff (!rst_n)
                (rstctl == '0) && !rst_req);
        end
    endgenerate
endmodule

bind sysreg_bank sysreg_bank_chk #(.AW(AW), .DW(DW), .IDENT(IDENT)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_err(bus_err),
    .rst_req(rst_req), .lock_val(lock_q), .unlocked(unlocked),
    .rstctl(state_q.rstctl)
);

// File: tb/sysreg_bank_tb_top.sv
module sysreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] rd_a, rd_b, rd_c;
    logic        err_a, err_b, err_c;
    logic        req_a, req_b, req_c;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sysreg_bank #(.IDENT(32'h0178_0000)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_a),
        .bus_err(err_a), .rst_req(req_a));
    sysreg_bank #(.IDENT(32'h0100_0000)) dut_b8 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_b),
        .bus_err(err_b), .rst_req(req_b));
    sysreg_bank #(.IDENT(32'h0140_0000)) dut_none (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_c),
        .bus_err(err_c), .rst_req(req_c));

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'h0,          32'h0178_0000, 1'b0}, // R1
        '{1'b1, 12'h008, 32'hA5A5_0F0F,  32'h0,         1'b0},
        '{1'b0, 12'h008, 32'h0,          32'hA5A5_0F0F, 1'b0}, // R8
        '{1'b1, 12'h030, 32'h0000_00F0,  32'h0,         1'b0},
        '{1'b1, 12'h030, 32'h0000_0003,  32'h0,         1'b0},
        '{1'b0, 12'h030, 32'h0,          32'h0000_00F3, 1'b0}, // R6
        '{1'b1, 12'h034, 32'h0000_0011,  32'h0,         1'b0},
        '{1'b0, 12'h030, 32'h0,          32'h0000_00E2, 1'b0}, // R6
        '{1'b0, 12'h034, 32'h0,          32'h0,         1'b0}, // R6
        '{1'b1, 12'h03C, 32'hFFFF_FFFF,  32'h0,         1'b0},
        '{1'b1, 12'h038, 32'hFFFF_FFFF,  32'h0,         1'b0},
        '{1'b1, 12'h03C, 32'h0F0F_0F0F,  32'h0,         1'b0},
        '{1'b0, 12'h038, 32'h0,          32'hF0F0_F0F0, 1'b0}, // R7
        '{1'b0, 12'h044, 32'h0,          32'h0000_0001, 1'b0}, // R9
        '{1'b0, 12'h088, 32'h0,          32'hFF00_0000, 1'b0}, // R9
        '{1'b1, 12'h020, 32'hFFFF_1234,  32'h0,         1'b0},
        '{1'b0, 12'h020, 32'h0,          32'h0000_1234, 1'b0}, // R2
        '{1'b1, 12'h020, 32'h0000_FFFF,  32'h0,         1'b0},
        '{1'b0, 12'h020, 32'h0,          32'h0000_7FFF, 1'b0}, // R2
        '{1'b1, 12'h000, 32'hFFFF_FFFF,  32'h0,         1'b0},
        '{1'b0, 12'h000, 32'h0,          32'h0178_0000, 1'b0}, // R1
        '{1'b0, 12'h100, 32'h0,          32'h0,         1'b1}  // R11
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        rd(12'h008); check("R10 led", rd_a, 32'h0);
        rd(12'h020); check("R10 lock", rd_a, 32'h0);
        rd(12'h030); check("R10 flags", rd_a, 32'h0);
        rd(12'h040); check("R10 rstctl", rd_a, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) begin
                wr(VEC[i].addr, VEC[i].data);
                check("R11 write err", {31'b0, err_a}, {31'b0, VEC[i].err});
            end else begin
                rd(VEC[i].addr);
                check($sformatf("vec %0d rdata", i), rd_a, VEC[i].exp);
                check($sformatf("vec %0d R11 err", i), {31'b0, err_a}, {31'b0, VEC[i].err});
            end
        end

        // R11: undecoded write flagged, nothing changed
        wr(12'h0FC, 32'hDEAD_BEEF);
        check("R11 wr err", {31'b0, err_a}, 32'h1);
        @(negedge clk);
        check("R11 err one cycle", {31'b0, err_a}, 32'h0);

        // R3: locked write dropped (lock holds 0x7FFF)
        wr(12'h040, 32'h0000_0104);
        check("R3 no req locked", {31'b0, req_a}, 32'h0);
        rd(12'h040); check("R3 dropped", rd_a, 32'h0);

        // R2/R4: unlock then write
        wr(12'h020, 32'h0000_A05F);
        rd(12'h020); check("R2 key stored", rd_a, 32'h0000_A05F);
        wr(12'h040, 32'h0000_0104);
        check("R4 req bit2", {31'b0, req_a}, 32'h1);
        check("R4 req bit8", {31'b0, req_b}, 32'h1);
        check("R5 no req", {31'b0, req_c}, 32'h0);
        @(negedge clk);
        check("R4 pulse one cycle", {31'b0, req_a}, 32'h0);
        rd(12'h040);
        check("R4 readback", rd_a, 32'h0000_0104);
        check("R4 readback b8", rd_b, 32'h0000_0104);
        check("R5 reads zero", rd_c, 32'h0);
        wr(12'h040, 32'h0000_0100);
        check("R4 bit2 clear", {31'b0, req_a}, 32'h0);
        check("R4 bit8 set", {31'b0, req_b}, 32'h1);

        // R10 / R7: reset clears volatile state, keeps persistent flags
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(12'h008); check("R10 led", rd_a, 32'h0);
        rd(12'h020); check("R10 lock", rd_a, 32'h0);
        rd(12'h030); check("R10 flags", rd_a, 32'h0);
        rd(12'h040); check("R10 rstctl", rd_a, 32'h0);
        rd(12'h038); check("R7 kept", rd_a, 32'hF0F0_F0F0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule